// File: doc/BRIEF.md
# Interrupt distributor register file

This block is the register front of the shared-interrupt distributor in an interrupt controller that always runs with affinity routing enabled and a single security state. A plain 32-bit register bus (byte address, write data, write strobe, read strobe, read data) reaches a 64 KiB frame. Behind it the block holds one enable bit and one pending bit per shared interrupt, a two-bit configuration field per shared interrupt, and a global group-1 enable. It also answers fixed control, type and identification words.

Enable and pending state are changed through separate set and clear views, where a one in the write data acts on the matching interrupt and a zero leaves it alone. Words that would cover the 32 private interrupts, words beyond the configured interrupt count, and every reserved or undecoded address read as zero and drop writes. The block drives one flag per interrupt that is high while the global group-1 enable is on and that interrupt is both enabled and pending. Delivery to a CPU interface happens elsewhere.

The interrupt count is the parameter `NUM_IRQS` (a multiple of 32, from 64 to 1024; default 256). Only the upper 14 address bits select a word, so the two lowest address bits are ignored.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset, bus_rdata is 0, irq_fire is all zero, group-1 enable is 0, and every enable, pending and configuration bit reads 0.
- R2: The control word at 0x000 reads bit 4 = 1 and bit 6 = 1 at all times, bit 1 = the group-1 enable and all other bits 0. A write stores write-data bit 1 as the group-1 enable. A write that sets bit 0, or that clears bit 4 or bit 6, changes none of them (writing 0x1 reads back 0x50, writing 0xFFFFFFFF reads back 0x52).
- R3: The type word at 0x004 reads min(NUM_IRQS,1024)/32−1 in bits [4:0] and 9 in bits [23:19], with all other bits 0 (0x00480007 for 256 interrupts). Writes to it are ignored.
- R4: Enable set view at 0x100 and clear view at 0x180. Word n covers interrupts 32n..32n+31, bit i being interrupt 32n+i. Writing 1 to a bit in the set view enables that interrupt, writing 1 in the clear view disables it, and writing 0 has no effect. A read of either view returns the current enable bits.
- R5: Pending set view at 0x200 and clear view at 0x280 follow the same layout and write-1 rules as R4, and a read of either view returns the current pending bits.
- R6: In the four bit banks, word 0 (interrupts 0..31) and every word at or beyond NUM_IRQS/32 read 0 and ignore writes, as do configuration words 0 and 1 (0xC00, 0xC04) and configuration words at or beyond NUM_IRQS/16. irq_fire[31:0] is always 0.
- R7: Every word from 0x080 to 0x0FC reads 0xFFFFFFFF and ignores writes.
- R8: The configuration bank at 0xC00 holds 2 bits per interrupt, 16 interrupts per word. Each shared word stores the full write data and reads it back unchanged.
- R9: The word at 0xFFE8 reads 0x3B. Every other word in 0xFFD0..0xFFFC reads 0, and writes there are ignored.
- R10: All other addresses read 0 and ignore writes. These include 0x010, 0x040, 0x048, 0x050, 0x058, 0x300, 0x380, 0x800..0xBFC, 0xD00, 0xE00, 0xF00, 0xF10 and 0xF20. Such writes change no stored state.
- R11: irq_fire[k] is 1 exactly when the group-1 enable is 1 and interrupt k is both enabled and pending. It follows the state from the clock edge that registers a write.
- R12: bus_rdata takes the addressed word at the clock edge where bus_re is sampled high, so it is valid in the following cycle. It holds its value while bus_re is low.
- R13: When bus_re and bus_we are both high for the same address in one cycle, the read returns the value from before that write. The write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Byte address within the 64 KiB frame |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_fire | output | NUM_IRQS | Per-interrupt enabled-and-pending-and-group-1-on flag |

## Verification
A read and a write can land on the same register in one cycle, because the bus has separate read and write strobes. The bench raises both strobes together on a set-enable word that currently holds zero. It expects the returned data to be the old zero, and a following plain read to show the newly set bits. The bench also checks that writes to reserved ranges, arriving between other operations, leave earlier enable and configuration contents intact.

// File: rtl/dist_pkg.sv
package dist_pkg;

  typedef enum logic [3:0] {
    RG_ZERO,
    RG_CTRL,
    RG_TYPE,
    RG_ONES,
    RG_SETEN,
    RG_CLREN,
    RG_SETPD,
    RG_CLRPD,
    RG_CFG,
    RG_IDENT
  } region_e;

  localparam int unsigned CTRL_G1_BIT    = 1;
  localparam int unsigned CTRL_ROUTE_BIT = 4;
  localparam int unsigned CTRL_ONESEC_BIT = 6;
  localparam int unsigned ID_BITS        = 10;
  localparam logic [31:0] IDENT_WORD     = 32'h0000_003B;

  // word offsets (byte address >> 2)
  localparam logic [13:0] WADDR_CTRL  = 14'h0000;
  localparam logic [13:0] WADDR_TYPE  = 14'h0001;
  localparam logic [13:0] WADDR_IDENT = 14'h3FFA;

  function automatic logic [31:0] type_word(input int unsigned n);
    int unsigned capped;
    logic [31:0] v;
    capped = (n > 1024) ? 1024 : n;
    v = '0;
    v[4:0]   = 5'(capped / 32 - 1);
    v[23:19] = 5'(ID_BITS - 1);
    return v;
  endfunction

endpackage

// File: rtl/dist_addr_decode.sv
module dist_addr_decode
  import dist_pkg::*;
#(
  parameter int unsigned NUM_IRQS = 256
) (
  input  logic [15:0] addr,
  output region_e     region,
  output logic [4:0]  bit_word,
  output logic [5:0]  cfg_word
);

  localparam int unsigned BIT_WORDS = NUM_IRQS / 32;
  localparam int unsigned CFG_WORDS = NUM_IRQS / 16;

  logic [13:0] waddr;
  logic        bit_ok;
  logic        cfg_ok;
  logic        unused_lsb;

  assign waddr      = addr[15:2];
  assign unused_lsb = ^addr[1:0];
  assign bit_word   = waddr[4:0];
  assign cfg_word   = waddr[5:0];

  // shared-interrupt words only; private and out-of-range words fall to zero
  assign bit_ok = (bit_word != 5'd0) && (32'(bit_word) < BIT_WORDS);
  assign cfg_ok = (cfg_word >= 6'd2) && (32'(cfg_word) < CFG_WORDS);

  always_comb begin
    region = RG_ZERO;
    if (waddr == WADDR_CTRL) begin
      region = RG_CTRL;
    end else if (waddr == WADDR_TYPE) begin
      region = RG_TYPE;
    end else if (waddr == WADDR_IDENT) begin
      region = RG_IDENT;
    end else begin
      case (waddr[13:5])
        9'd1: region = RG_ONES;
        9'd2: region = bit_ok ? RG_SETEN : RG_ZERO;
        9'd3: region = bit_ok ? RG_CLREN : RG_ZERO;
        9'd4: region = bit_ok ? RG_SETPD : RG_ZERO;
        9'd5: region = bit_ok ? RG_CLRPD : RG_ZERO;
        default: begin
          if (waddr[13:6] == 8'h0C) region = cfg_ok ? RG_CFG : RG_ZERO;
        end
      endcase
    end
  end

endmodule

// File: rtl/dist_bit_bank.sv
module dist_bit_bank #(
  parameter int unsigned NUM_IRQS = 256,
  localparam int unsigned WORDS   = NUM_IRQS / 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic [4:0]             word_sel,
  input  logic [31:0]            wmask,
  output logic [WORDS-1:0][31:0] word_q
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == 0) begin : g_private
      assign word_q[w] = '0;
    end else begin : g_shared
      logic        hit;
      logic        upd;
      logic [31:0] q;
      logic [31:0] nxt;

      assign hit = (word_sel == 5'(w));
      assign upd = hit && (set_en || clr_en);

      always_comb begin
        nxt = q;
        if (set_en) nxt = nxt | wmask;
        if (clr_en) nxt = nxt & ~wmask;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (upd) begin
          q <= nxt;
        end
      end

      assign word_q[w] = q;
    end
  end

endmodule

// File: rtl/dist_cfg_bank.sv
module dist_cfg_bank #(
  parameter int unsigned NUM_IRQS = 256,
  localparam int unsigned WORDS   = NUM_IRQS / 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [5:0]             word_sel,
  input  logic [31:0]            wdata,
  output logic [WORDS-1:0][31:0] word_q
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w < 2) begin : g_private
      assign word_q[w] = '0;
    end else begin : g_shared
      logic        upd;
      logic [31:0] q;

      assign upd = wr_en && (word_sel == 6'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (upd) begin
          q <= wdata;
        end
      end

      assign word_q[w] = q;
    end
  end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import dist_pkg::*;
#(
  parameter int unsigned NUM_IRQS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [31:0]         bus_rdata,
  output logic [NUM_IRQS-1:0] irq_fire
);

  localparam int unsigned BIT_WORDS = NUM_IRQS / 32;
  localparam int unsigned CFG_WORDS = NUM_IRQS / 16;
  localparam logic [31:0] TYPE_WORD = type_word(NUM_IRQS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign core_rst_n = rst_pipe[1];

  // address decode
  region_e    region;
  logic [4:0] bit_word;
  logic [5:0] cfg_word;

  dist_addr_decode #(.NUM_IRQS(NUM_IRQS)) u_decode (
    .addr     (bus_addr),
    .region   (region),
    .bit_word (bit_word),
    .cfg_word (cfg_word)
  );

  // write strobes per region
  logic ctrl_we, en_set_we, en_clr_we, pd_set_we, pd_clr_we, cfg_we;

  assign ctrl_we   = bus_we && (region == RG_CTRL);
  assign en_set_we = bus_we && (region == RG_SETEN);
  assign en_clr_we = bus_we && (region == RG_CLREN);
  assign pd_set_we = bus_we && (region == RG_SETPD);
  assign pd_clr_we = bus_we && (region == RG_CLRPD);
  assign cfg_we    = bus_we && (region == RG_CFG);

  // group-1 enable
  logic g1_q;
  logic g1_nxt;

  always_comb begin
    g1_nxt = bus_wdata[CTRL_G1_BIT];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      g1_q <= 1'b0;
    end else if (ctrl_we) begin
      g1_q <= g1_nxt;
    end
  end

  // state banks
  logic [BIT_WORDS-1:0][31:0] en_words;
  logic [BIT_WORDS-1:0][31:0] pd_words;
  logic [CFG_WORDS-1:0][31:0] cfg_words;

  dist_bit_bank #(.NUM_IRQS(NUM_IRQS)) u_enable (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .set_en   (en_set_we),
    .clr_en   (en_clr_we),
    .word_sel (bit_word),
    .wmask    (bus_wdata),
    .word_q   (en_words)
  );

  dist_bit_bank #(.NUM_IRQS(NUM_IRQS)) u_pending (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .set_en   (pd_set_we),
    .clr_en   (pd_clr_we),
    .word_sel (bit_word),
    .wmask    (bus_wdata),
    .word_q   (pd_words)
  );

  dist_cfg_bank #(.NUM_IRQS(NUM_IRQS)) u_config (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (cfg_we),
    .word_sel (cfg_word),
    .wdata    (bus_wdata),
    .word_q   (cfg_words)
  );

  // per-interrupt output
  logic [NUM_IRQS-1:0] en_flat;
  logic [NUM_IRQS-1:0] pd_flat;

  assign en_flat  = en_words;
  assign pd_flat  = pd_words;
  assign irq_fire = en_flat & pd_flat & {NUM_IRQS{g1_q}};

  // read path
  logic [31:0] ctrl_word;
  logic [31:0] rd_val;
  logic [31:0] rdata_q;

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[CTRL_G1_BIT]     = g1_q;
    ctrl_word[CTRL_ROUTE_BIT]  = 1'b1;
    ctrl_word[CTRL_ONESEC_BIT] = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    case (region)
      RG_CTRL:  rd_val = ctrl_word;
      RG_TYPE:  rd_val = TYPE_WORD;
      RG_ONES:  rd_val = '1;
      RG_IDENT: rd_val = IDENT_WORD;
      RG_SETEN, RG_CLREN: begin
        for (int unsigned w = 0; w < BIT_WORDS; w++) begin
          if (bit_word == 5'(w)) rd_val = en_words[w];
        end
      end
      RG_SETPD, RG_CLRPD: begin
        for (int unsigned w = 0; w < BIT_WORDS; w++) begin
          if (bit_word == 5'(w)) rd_val = pd_words[w];
        end
      end
      RG_CFG: begin
        for (int unsigned w = 0; w < CFG_WORDS; w++) begin
          if (cfg_word == 6'(w)) rd_val = cfg_words[w];
        end
      end
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/dist_regs_chk.sv
module dist_regs_chk #(
  parameter int unsigned NUM_IRQS = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic [15:0]         bus_addr,
  input logic [31:0]         bus_wdata,
  input logic                bus_we,
  input logic                bus_re,
  input logic [31:0]         bus_rdata,
  input logic [NUM_IRQS-1:0] irq_fire
);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:2], bus_wdata[0]};

  // R2: fixed control bits always read as one, group 0 never reported
  assert_ctrl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[15:2] == 14'd0) |=> (bus_rdata[6] && bus_rdata[4] && !bus_rdata[0]));

  // R6: private interrupts never flagged
  assert_private_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire[31:0] == 32'd0);

  // R7: group bank reads all ones
  assert_group_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[15:7] == 9'd1) |=> bus_rdata == 32'hFFFF_FFFF);

  // R9: identification word
  assert_ident_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[15:2] == 14'h3FFA) |=> bus_rdata == 32'h0000_003B);

  // R10: status word reads zero
  assert_status_raz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[15:2] == 14'd4) |=> bus_rdata == 32'd0);

  // R11: clearing group-1 enable silences every flag
  assert_g1_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[15:2] == 14'd0 && !bus_wdata[1]) |=> irq_fire == '0);

  // R12: read data holds without a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind irq_dist_regs dist_regs_chk #(.NUM_IRQS(NUM_IRQS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .irq_fire  (irq_fire)
);

// File: tb/irq_dist_regs_test.sv
module irq_dist_regs_test;

  localparam int unsigned N = 256;

  logic          clk;
  logic          rst_n;
  logic [15:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_we;
  logic          bus_re;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_fire;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_dist_regs #(.NUM_IRQS(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_fire  (irq_fire)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 irq_fire low", 32'(irq_fire != '0), 32'h0);
    rd_check("R1 ctrl reset", 16'h0000, 32'h0000_0050);
    rd_check("R1 enable reset", 16'h0104, 32'h0);
    rd_check("R1 pending reset", 16'h0204, 32'h0);
    rd_check("R1 config reset", 16'h0C08, 32'h0);
  endtask

  task automatic t_ctrl();
    bus_wr(16'h0000, 32'hFFFF_FFFF);
    rd_check("R2 ctrl all ones", 16'h0000, 32'h0000_0052);
    bus_wr(16'h0000, 32'h0000_0001);
    rd_check("R2 ctrl group0 only", 16'h0000, 32'h0000_0050);
  endtask

  task automatic t_type();
    bus_wr(16'h0004, 32'h1234_5678);
    rd_check("R3 type word", 16'h0004, 32'h0048_0007);
  endtask

  task automatic t_enable();
    bus_wr(16'h0104, 32'h0000_00F0);
    rd_check("R4 set view", 16'h0104, 32'h0000_00F0);
    rd_check("R4 clear view read", 16'h0184, 32'h0000_00F0);
    bus_wr(16'h0184, 32'h0000_0030);
    rd_check("R4 clear bits", 16'h0104, 32'h0000_00C0);
    bus_wr(16'h0104, 32'h0);
    bus_wr(16'h0184, 32'h0);
    rd_check("R4 zero write no effect", 16'h0104, 32'h0000_00C0);
  endtask

  task automatic t_pending();
    bus_wr(16'h0208, 32'h8000_0001);
    rd_check("R5 set pending", 16'h0208, 32'h8000_0001);
    bus_wr(16'h0288, 32'h0000_0001);
    rd_check("R5 clear pending", 16'h0288, 32'h8000_0000);
    bus_wr(16'h0288, 32'h8000_0000);
    rd_check("R5 clear rest", 16'h0208, 32'h0);
  endtask

  task automatic t_fire();
    bus_wr(16'h0000, 32'h0000_0002);
    bus_wr(16'h010C, 32'h0000_0001);  // enable irq 96
    check("R11 enabled not pending", 32'(irq_fire[96]), 32'h0);
    bus_wr(16'h020C, 32'h0000_0001);  // pend irq 96
    check("R11 enabled and pending", 32'(irq_fire[96]), 32'h1);
    check("R11 enabled only irq 38", 32'(irq_fire[38]), 32'h0);
    bus_wr(16'h0000, 32'h0);
    check("R11 group1 off", 32'(irq_fire[96]), 32'h0);
    bus_wr(16'h0000, 32'h0000_0002);
    check("R11 group1 back on", 32'(irq_fire[96]), 32'h1);
    bus_wr(16'h028C, 32'h0000_0001);
    check("R11 pending cleared", 32'(irq_fire[96]), 32'h0);
  endtask

  task automatic t_private();
    bus_wr(16'h0100, 32'hFFFF_FFFF);
    bus_wr(16'h0200, 32'hFFFF_FFFF);
    bus_wr(16'h0C00, 32'hFFFF_FFFF);
    bus_wr(16'h0C04, 32'hFFFF_FFFF);
    bus_wr(16'h0120, 32'hFFFF_FFFF);  // beyond 256 interrupts
    check("R6 private flags low", irq_fire[31:0], 32'h0);
    rd_check("R6 private enable word", 16'h0100, 32'h0);
    rd_check("R6 private pending word", 16'h0280, 32'h0);
    rd_check("R6 private config word0", 16'h0C00, 32'h0);
    rd_check("R6 private config word1", 16'h0C04, 32'h0);
    rd_check("R6 out of range word", 16'h0120, 32'h0);
    bus_wr(16'h0000, 32'h0);
  endtask

  task automatic t_group();
    bus_wr(16'h0080, 32'h0);
    rd_check("R7 group first", 16'h0080, 32'hFFFF_FFFF);
    rd_check("R7 group last", 16'h00FC, 32'hFFFF_FFFF);
  endtask

  task automatic t_config();
    bus_wr(16'h0C08, 32'hA5A5_5A5A);
    bus_wr(16'h0C3C, 32'h1234_ABCD);
    rd_check("R8 config word2", 16'h0C08, 32'hA5A5_5A5A);
    rd_check("R8 config last", 16'h0C3C, 32'h1234_ABCD);
    rd_check("R6 config past end", 16'h0C40, 32'h0);
  endtask

  task automatic t_ident();
    bus_wr(16'hFFE8, 32'hFFFF_FFFF);
    rd_check("R9 ident word", 16'hFFE8, 32'h0000_003B);
    rd_check("R9 ident first", 16'hFFD0, 32'h0);
    rd_check("R9 ident last", 16'hFFFC, 32'h0);
  endtask

  task automatic t_reserved();
    logic [15:0] addrs [15] = '{16'h0010, 16'h0040, 16'h0048, 16'h0050, 16'h0058,
                                16'h0300, 16'h0380, 16'h0800, 16'h0BFC, 16'h0D00,
                                16'h0E00, 16'h0F00, 16'h0F10, 16'h0F20, 16'h4000};
    for (int i = 0; i < 15; i++) bus_wr(addrs[i], 32'hFFFF_FFFF);
    for (int i = 0; i < 15; i++) rd_check($sformatf("R10 reserved %h", addrs[i]), addrs[i], 32'h0);
    rd_check("R10 enable intact", 16'h0104, 32'h0000_00C0);
    rd_check("R10 config intact", 16'h0C08, 32'hA5A5_5A5A);
    rd_check("R10 ctrl intact", 16'h0000, 32'h0000_0050);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    bus_rd(16'h0104, d);
    check("R12 one cycle read", d, 32'h0000_00C0);
    @(negedge clk);
    bus_addr = 16'h0080;
    @(negedge clk);
    @(negedge clk);
    check("R12 hold without strobe", bus_rdata, 32'h0000_00C0);
  endtask

  task automatic t_concurrent();
    @(negedge clk);
    bus_addr = 16'h0108; bus_wdata = 32'h0000_0011; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check("R13 read returns old", bus_rdata, 32'h0);
    rd_check("R13 write landed", 16'h0108, 32'h0000_0011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_type();
    t_enable();
    t_pending();
    t_fire();
    t_private();
    t_group();
    t_config();
    t_ident();
    t_reserved();
    t_latency();
    t_concurrent();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule